// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the configuration front end of a two-channel voice coding device. A host shares a three-wire serial bus (serial clock, serial data, active-low select) among up to 64 such devices. Each transfer opens with a header byte. The header names one device through a six-bit address and picks one of two channels, X or Y. The device whose six address straps equal the header address accepts the next three bytes. These are stored as that channel's control byte, input timeslot and output timeslot. Every other device on the bus discards the rest of the transfer.

The control byte holds five flags: idle, algorithm reset, bypass, law select and coding direction. Setting the algorithm-reset flag starts a fixed-length reset pulse toward the coding core. When the pulse ends, the flag clears itself.

A mode strap can force the block into a pin-driven mode. In that mode the serial port is dead and every stored register is held at zero. Each channel's idle, law and coding flags are then driven by dedicated pins, and the timeslots read as zero. The serial inputs are synchronised to the system clock, and bit edges are found by sampling the serial clock.

Top module: `cfg_port_top`

## Requirements
- R1: After reset with the mode strap high, every control and timeslot output of both channels reads 0 and both reset pulses are low.
- R2: While select is low, a data bit is taken on each rising serial clock edge, most significant bit first, and every eighth bit closes a byte.
- R3: In the header byte, bits 5..0 are the address and bit 6 selects the channel (1 = X, 0 = Y). When the address equals the straps, only the selected channel is updated and the other channel keeps its values.
- R4: When the header address differs from the straps, the rest of the transfer leaves both channels unchanged.
- R5: A header with bit 7 set is treated as a mismatch, and the transfer changes nothing.
- R6: After a matching header, bytes two, three and four go to control, input timeslot and output timeslot in that order. Any later byte in the same transfer is ignored.
- R7: The control byte maps bit 4 to idle, bit 3 to algorithm reset, bit 2 to bypass, bit 1 to law (1 = mu-law, 0 = A-law) and bit 0 to coding (1 = compress, 0 = expand). Bits 7..5 are discarded. The control output carries the same flags at the same positions, 4..0.
- R8: Writing a control byte with bit 3 set drives that channel's reset pulse high for exactly ALRST_CYC clock cycles, with the stored flag visible during the pulse. After the pulse the flag reads 0. The other channel's pulse stays low.
- R9: Raising select drops any partial byte, and the next transfer starts again with a header byte.
- R10: With the mode strap low, each channel's control output reads {idle pin, 0, 0, law pin, coding pin}, all timeslots read 0, and serial traffic has no effect.
- R11: Registers are cleared while the mode strap is low, so on return to serial mode all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sw | input | 1 | Mode strap: 1 = serial mode, 0 = pin mode |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_cs_n | input | 1 | Active-low transfer select |
| dev_addr | input | ADDR_W | Device address straps |
| hw_idle_x | input | 1 | Pin-mode idle flag, channel X |
| hw_law_x | input | 1 | Pin-mode law flag, channel X |
| hw_comp_x | input | 1 | Pin-mode coding flag, channel X |
| hw_idle_y | input | 1 | Pin-mode idle flag, channel Y |
| hw_law_y | input | 1 | Pin-mode law flag, channel Y |
| hw_comp_y | input | 1 | Pin-mode coding flag, channel Y |
| x_ctrl | output | 5 | Channel X control flags |
| x_ts_in | output | 8 | Channel X input timeslot |
| x_ts_out | output | 8 | Channel X output timeslot |
| x_alg_rst | output | 1 | Channel X algorithm reset pulse |
| y_ctrl | output | 5 | Channel Y control flags |
| y_ts_in | output | 8 | Channel Y input timeslot |
| y_ts_out | output | 8 | Channel Y output timeslot |
| y_alg_rst | output | 1 | Channel Y algorithm reset pulse |

## Verification
Some properties are checked on every cycle. Bytes complete only while select is active. The byte index stays in range, and writes happen only inside a transfer. Stored registers empty out one cycle after the mode strap falls. The reset-pulse timer never exceeds its length, and the pulse is always backed by the stored flag.

Other behaviour can only be shown by the bench scenarios. These cover the address comparison across all 64 header addresses, the byte-to-register order, dropping of a fifth byte, the exact pulse length and self-clearing, and the 64 pin combinations of the fallback mode.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int BYTE_W  = 8;
    localparam int CTRL_W  = 5;
    // control flag positions
    localparam int C_IDLE  = 4;
    localparam int C_ALRST = 3;
    localparam int C_BYP   = 2;
    localparam int C_LAW   = 1;
    localparam int C_COMP  = 0;
    // header fields
    localparam int HDR_RSV = 7;
    localparam int HDR_CH  = 6;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TSIN  = 2'd1,
        SEL_TSOUT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfg_port_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_cs_n,
    output logic              xfer_act,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int BCNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [SYNC-1:0]   sclk_sr;
        logic [SYNC-1:0]   din_sr;
        logic [SYNC-1:0]   csn_sr;
        logic              sclk_prev;
        logic [BYTE_W-1:0] sh;
        logic [BCNT_W-1:0] cnt;
        logic              vld;
    } shift_t;

    shift_t q, d;
    logic   sclk_s, din_s, csn_s, act;

    assign sclk_s = q.sclk_sr[SYNC-1];
    assign din_s  = q.din_sr[SYNC-1];
    assign csn_s  = q.csn_sr[SYNC-1];
    assign act    = enable && !csn_s;

    always_comb begin
        d           = q;
        d.sclk_sr   = {q.sclk_sr[SYNC-2:0], ser_clk};
        d.din_sr    = {q.din_sr[SYNC-2:0], ser_din};
        d.csn_sr    = {q.csn_sr[SYNC-2:0], ser_cs_n};
        d.sclk_prev = sclk_s;
        d.vld       = 1'b0;
        if (!act) begin
            d.cnt = '0;
        end else if (sclk_s && !q.sclk_prev) begin
            d.sh  = {q.sh[BYTE_W-2:0], din_s};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == BCNT_W'(BYTE_W - 1)) begin
                d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.csn_sr <= '1;
        end else begin
            q <= d;
        end
    end

    assign xfer_act  = act;
    assign byte_vld  = q.vld;
    assign byte_data = q.sh;

    // R2
    vld_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(act));
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_act,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              wr_en,
    output logic              wr_x,
    output reg_sel_e          wr_sel,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int NREG  = 3;
    localparam int IDX_W = $clog2(NREG + 2);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              match;
        logic              sel_x;
        logic              wr_en;
        logic              wr_x;
        reg_sel_e          wr_sel;
        logic [BYTE_W-1:0] wr_data;
    } dec_t;

    dec_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (!xfer_act) begin
            d.idx   = '0;
            d.match = 1'b0;
        end else if (byte_vld) begin
            if (q.idx == '0) begin
                d.match = !byte_data[HDR_RSV] &&
                          (byte_data[ADDR_W-1:0] == dev_addr);
                d.sel_x = byte_data[HDR_CH];
                d.idx   = IDX_W'(1);
            end else if (q.idx <= IDX_W'(NREG)) begin
                if (q.match) begin
                    d.wr_en   = 1'b1;
                    d.wr_x    = q.sel_x;
                    d.wr_sel  = reg_sel_e'(q.idx[1:0] - 2'd1);
                    d.wr_data = byte_data;
                end
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.wr_sel <= SEL_NONE;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr_en;
    assign wr_x    = q.wr_x;
    assign wr_sel  = q.wr_sel;
    assign wr_data = q.wr_data;

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_W'(NREG + 1));
    // R4
    wr_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(xfer_act));
endmodule

// File: rtl/cfg_chan.sv
module cfg_chan
    import cfg_port_pkg::*;
#(
    parameter int ALRST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_mode,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl,
    output logic [BYTE_W-1:0] ts_in,
    output logic [BYTE_W-1:0] ts_out,
    output logic              alg_rst
);
    localparam int TMR_W = $clog2(ALRST_CYC + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [BYTE_W-1:0] ts_in;
        logic [BYTE_W-1:0] ts_out;
        logic [TMR_W-1:0]  tmr;
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
            if (q.tmr == TMR_W'(1)) begin
                d.ctrl[C_ALRST] = 1'b0;
            end
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    d.ctrl = wr_data[CTRL_W-1:0];
                    d.tmr  = wr_data[C_ALRST] ? TMR_W'(ALRST_CYC) : '0;
                end
                SEL_TSIN:  d.ts_in  = wr_data;
                SEL_TSOUT: d.ts_out = wr_data;
                default: ;
            endcase
        end
        if (!soft_mode) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl    = q.ctrl;
    assign ts_in   = q.ts_in;
    assign ts_out  = q.ts_out;
    assign alg_rst = (q.tmr != '0);

    // R11
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_mode |=> (ctrl == '0 && ts_in == '0 && ts_out == '0 && !alg_rst));
    // R8
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alg_rst |-> ctrl[C_ALRST]);
    // R8
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmr <= TMR_W'(ALRST_CYC));
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SYNC      = 2,
    parameter int ALRST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sw,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_cs_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              hw_idle_x,
    input  logic              hw_law_x,
    input  logic              hw_comp_x,
    input  logic              hw_idle_y,
    input  logic              hw_law_y,
    input  logic              hw_comp_y,
    output logic [4:0]        x_ctrl,
    output logic [7:0]        x_ts_in,
    output logic [7:0]        x_ts_out,
    output logic              x_alg_rst,
    output logic [4:0]        y_ctrl,
    output logic [7:0]        y_ts_in,
    output logic [7:0]        y_ts_out,
    output logic              y_alg_rst
);
    localparam int NCH = 2; // index 0 = X, 1 = Y

    logic              xfer_act, byte_vld, wr_en, wr_x;
    logic [BYTE_W-1:0] byte_data, wr_data;
    reg_sel_e          wr_sel;

    logic [CTRL_W-1:0] ctrl_r [NCH];
    logic [BYTE_W-1:0] tsi_r  [NCH];
    logic [BYTE_W-1:0] tso_r  [NCH];
    logic              pulse_r[NCH];
    logic [CTRL_W-1:0] hw_ctrl[NCH];

    cfg_shift #(.SYNC(SYNC)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(mode_sw),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_cs_n(ser_cs_n),
        .xfer_act(xfer_act), .byte_vld(byte_vld), .byte_data(byte_data)
    );

    cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .xfer_act(xfer_act),
        .byte_vld(byte_vld), .byte_data(byte_data), .dev_addr(dev_addr),
        .wr_en(wr_en), .wr_x(wr_x), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    assign hw_ctrl[0] = {hw_idle_x, 1'b0, 1'b0, hw_law_x, hw_comp_x};
    assign hw_ctrl[1] = {hw_idle_y, 1'b0, 1'b0, hw_law_y, hw_comp_y};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ch_wr;
        assign ch_wr = wr_en && (wr_x == (c == 0));
        cfg_chan #(.ALRST_CYC(ALRST_CYC)) u_chan (
            .clk(clk), .rst_n(rst_n), .soft_mode(mode_sw),
            .wr_en(ch_wr), .wr_sel(wr_sel), .wr_data(wr_data),
            .ctrl(ctrl_r[c]), .ts_in(tsi_r[c]), .ts_out(tso_r[c]),
            .alg_rst(pulse_r[c])
        );
    end

    assign x_ctrl    = mode_sw ? ctrl_r[0] : hw_ctrl[0];
    assign y_ctrl    = mode_sw ? ctrl_r[1] : hw_ctrl[1];
    assign x_ts_in   = tsi_r[0];
    assign x_ts_out  = tso_r[0];
    assign y_ts_in   = tsi_r[1];
    assign y_ts_out  = tso_r[1];
    assign x_alg_rst = pulse_r[0];
    assign y_alg_rst = pulse_r[1];
endmodule

// File: tb/sim_cfg_port_top.sv
module sim_cfg_port_top;
    localparam int HP  = 4;
    localparam int CYC = 4;

    logic clk = 0, rst_n = 0, mode_sw = 1;
    logic ser_clk = 0, ser_din = 0, ser_cs_n = 1;
    logic [5:0] dev_addr = 6'h2A;
    logic hw_idle_x = 0, hw_law_x = 0, hw_comp_x = 0;
    logic hw_idle_y = 0, hw_law_y = 0, hw_comp_y = 0;
    logic [4:0] x_ctrl, y_ctrl;
    logic [7:0] x_ts_in, x_ts_out, y_ts_in, y_ts_out;
    logic x_alg_rst, y_alg_rst;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [4:0] e_ctrl[2];
    logic [7:0] e_tsi[2], e_tso[2];
    int  px = 0, py = 0;
    bit  flag_seen = 0;

    always #4 clk = ~clk;

    cfg_port_top u0 (.*);

    always @(negedge clk) begin
        if (x_alg_rst) begin
            px++;
            if (x_ctrl[3]) flag_seen = 1;
        end
        if (y_alg_rst) py++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " x_ctrl"}, 32'(x_ctrl), 32'(e_ctrl[0]));
        chk({req, " x_ts_in"}, 32'(x_ts_in), 32'(e_tsi[0]));
        chk({req, " x_ts_out"}, 32'(x_ts_out), 32'(e_tso[0]));
        chk({req, " y_ctrl"}, 32'(y_ctrl), 32'(e_ctrl[1]));
        chk({req, " y_ts_in"}, 32'(y_ts_in), 32'(e_tsi[1]));
        chk({req, " y_ts_out"}, 32'(y_ts_out), 32'(e_tso[1]));
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            ser_din = b[i];
            wait_n(HP);
            ser_clk = 1;
            wait_n(HP);
            ser_clk = 0;
        end
    endtask

    task automatic open_x();
        ser_cs_n = 0;
        wait_n(4);
    endtask

    task automatic close_x();
        wait_n(4);
        ser_cs_n = 1;
        wait_n(12);
    endtask

    task automatic xfer4(logic [7:0] h, logic [7:0] c, logic [7:0] ti, logic [7:0] to);
        open_x();
        send_bits(h, 8); send_bits(c, 8); send_bits(ti, 8); send_bits(to, 8);
        close_x();
    endtask

    task automatic model(logic [7:0] h, logic [7:0] c, logic [7:0] ti, logic [7:0] to);
        int ch;
        if (!h[7] && h[5:0] == dev_addr) begin
            ch = h[6] ? 0 : 1;
            e_ctrl[ch] = {c[4], 1'b0, c[2:0]};
            e_tsi[ch]  = ti;
            e_tso[ch]  = to;
        end
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            e_ctrl[c] = 0; e_tsi[c] = 0; e_tso[c] = 0;
        end
        wait_n(3);
        rst_n = 1;
        wait_n(3);
        // R1
        chk_all("R1");
        chk("R1 pulses", 32'({x_alg_rst, y_alg_rst}), 0);

        // R2 R3 R7: matching header on every address, both channels
        for (int v = 0; v < 64; v++) begin
            logic [7:0] h, c, ti, to;
            dev_addr = 6'(v);
            h  = {1'b0, v[0], 6'(v)};
            c  = 8'((v * 37) & 8'hF7);
            ti = 8'(v ^ 8'h5A);
            to = 8'(255 - v * 3);
            xfer4(h, c, ti, to);
            model(h, c, ti, to);
            chk_all("R2 R3 R7 match");
        end

        // R4: every non-matching address leaves state alone
        dev_addr = 6'h2A;
        for (int a = 0; a < 64; a++) begin
            logic [7:0] h;
            if (a == 6'h2A) continue;
            h = {1'b0, a[1], 6'(a)};
            xfer4(h, 8'h17, 8'hEE, 8'hDD);
            model(h, 8'h17, 8'hEE, 8'hDD);
            chk_all("R4 mismatch");
        end

        // R5: reserved bit set
        xfer4(8'hC0 | 8'h2A, 8'h15, 8'h11, 8'h22);
        chk_all("R5 reserved");

        // R6: fifth byte dropped
        open_x();
        send_bits(8'h6A, 8); send_bits(8'h05, 8); send_bits(8'h33, 8);
        send_bits(8'h44, 8); send_bits(8'h99, 8);
        close_x();
        model(8'h6A, 8'h05, 8'h33, 8'h44);
        chk_all("R6 extra byte");

        // R9: partial byte aborted
        open_x();
        send_bits(8'hFF, 5);
        close_x();
        xfer4(8'h2A, 8'h12, 8'h71, 8'h72);
        model(8'h2A, 8'h12, 8'h71, 8'h72);
        chk_all("R9 abort");

        // R8: algorithm reset pulse on X
        px = 0; py = 0; flag_seen = 0;
        xfer4(8'h6A, 8'h0B, 8'h01, 8'h02);
        wait_n(10);
        model(8'h6A, 8'h0B, 8'h01, 8'h02);
        chk("R8 pulse length", 32'(px), CYC);
        chk("R8 flag during pulse", 32'(flag_seen), 1);
        chk("R8 flag cleared", 32'(x_ctrl[3]), 0);
        chk("R8 other channel", 32'(py), 0);
        chk_all("R8 regs");

        // R10: pin mode, all 64 pin combinations
        mode_sw = 0;
        wait_n(2);
        for (int p = 0; p < 64; p++) begin
            {hw_idle_x, hw_law_x, hw_comp_x, hw_idle_y, hw_law_y, hw_comp_y} = 6'(p);
            wait_n(1);
            chk("R10 x_ctrl", 32'(x_ctrl), 32'({p[5], 2'b00, p[4], p[3]}));
            chk("R10 y_ctrl", 32'(y_ctrl), 32'({p[2], 2'b00, p[1], p[0]}));
            chk("R10 ts", 32'({x_ts_in, x_ts_out, y_ts_in, y_ts_out}), 0);
        end
        xfer4(8'h6A, 8'h1F, 8'hAB, 8'hCD);
        chk("R10 serial ignored x", 32'({x_ctrl, x_ts_in, x_ts_out}),
            32'({p_last_x(), 16'h0}));
        chk("R10 pulses", 32'({x_alg_rst, y_alg_rst}), 0);

        // R11: registers cleared on return
        mode_sw = 1;
        wait_n(3);
        for (int c = 0; c < 2; c++) begin
            e_ctrl[c] = 0; e_tsi[c] = 0; e_tso[c] = 0;
        end
        chk_all("R11 cleared");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [4:0] p_last_x();
        return {hw_idle_x, 2'b00, hw_law_x, hw_comp_x};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule